// File: doc/BRIEF.md
# Eight-point DCT row engine

This block computes a one-dimensional eight-point discrete cosine transform over a group of eight signed 8-bit samples. It returns eight signed 11-bit coefficients. The result is the cosine matrix times the sample vector. The block is the arithmetic core of a row/column transform. Transposition, block storage and the inverse transform live elsewhere.

A transform begins with a one-cycle `start` pulse while the engine is idle. The samples then arrive on a valid/ready stream, `LANES` samples per beat, where `LANES` is 1, 2, 4 or 8. A beat transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the engine is still collecting the group. The sender may hold `in_valid` low for as long as it likes, which stalls capture without losing data. The sender must keep `in_data` steady only on cycles where it drives `in_valid` high. After the final beat, the engine runs a fixed compute tail:
- a butterfly add/subtract,
- an absolute value step,
- an unsigned multiply by stored cosine magnitudes,
- a two-cycle signed accumulation.

`done` then pulses, and the eight coefficients stay on `coef_out` until the next pulse.

Top module: `dct8_row`

## Requirements
- R1: Coefficient k equals the sum over n of x[n]·T(k,n), rounded as in R7. T(k,n) is ±q(m), taken from cos((2n+1)kπ/16) reduced to a first-quadrant index m with the sign of the cosine. The Q7 magnitudes are q(1..7) = 126, 118, 106, 91, 71, 49, 25. Row k=0 uses q(0)=45, which is 1/(2√2) in Q7.
- R2: Lane j of `in_data` sits at bits [8j+7:8j]. On the b-th accepted beat (counting from 0), lane j carries sample x[b·LANES+j]. Coefficient k is driven on `coef_out` bits [11k+10:11k].
- R3: Count the edge that accepts the first beat as edge 1. With beats sent back to back, `done` and the coefficients appear after edge 14, 9, 7 or 6 for LANES = 1, 2, 4 or 8. After the edge that takes the final beat, the tail lasts 6 edges for LANES=1 and 5 edges otherwise, whatever stalls came before it.
- R4: `in_ready` rises on the edge after an accepted `start`. It stays high until the 8/LANES-th beat has transferred, and it is low during the compute tail and while `done` is high. Cycles with `in_valid` low transfer nothing and do not alter the result.
- R5: A `start` seen while capture or the compute tail is in progress is ignored. The running transform completes on schedule, and no new capture opens after its `done`.
- R6: `done` is high for exactly one cycle per transform. `coef_out` changes only on the edge that raises `done`.
- R7: Rounding is half up. Row 0 adds 2^6 and then shifts right arithmetically by 7. The other rows add 2^7 and shift by 8. The result is then clamped to the signed 11-bit range.
- R8: Right after reset, `done` and `in_ready` are low and `coef_out` is zero.
- R9: Negative samples and the extremes −128 and 127 transform correctly. The sign of each term is kept apart and put back after the unsigned multiply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a new transform when the engine is idle |
| in_valid | input | 1 | Sample beat on `in_data` is valid |
| in_ready | output | 1 | Engine accepts a sample beat |
| in_data | input | LANES*8 | LANES signed samples, lane 0 in the low byte |
| coef_out | output | 88 | Eight signed 11-bit coefficients, k=0 in the low bits |
| done | output | 1 | One-cycle pulse when `coef_out` is updated |

## Verification
The patterns are chosen so that each one isolates a different kind of error:
- All zeros and all equal values put energy only into row 0, which separates the DC scaling from the others.
- Lone impulses at the first and last positions and a ramp expose lane or beat misordering, since each of those gives a distinct odd/even coefficient signature.
- Full-scale values of alternating sign and all −128 stress the sign-magnitude path and the widest butterfly results.
- Small inputs land on rounding boundaries.
- Random groups with random stalls show that idle cycles on the stream change neither the result nor the tail length.
- A start held high through a whole transform shows that the request is discarded.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

  localparam int NPT   = 8;   // points per transform
  localparam int NHALF = NPT / 2;
  localparam int CW    = 8;   // width of a stored cosine magnitude
  localparam int FRAC  = 7;   // fraction bits of the stored magnitudes

  typedef enum logic [2:0] {
    ST_IDLE, ST_CAP, ST_REG, ST_BFLY, ST_ABS, ST_MUL, ST_ACC1, ST_ACC2
  } dct_state_e;

  // phase index of cos((2n+1) k pi / 16), modulo a full turn
  function automatic int phase_idx(input int k, input int n);
    return ((2 * n + 1) * k) % 32;
  endfunction

  // first-quadrant index of the cosine magnitude
  function automatic int cos_sel(input int k, input int n);
    int a;
    a = phase_idx(k, n);
    if (a <= 8)       return a;
    else if (a <= 16) return 16 - a;
    else if (a <= 24) return a - 16;
    else              return 32 - a;
  endfunction

  // cosine is negative in the second and third quadrant
  function automatic bit cos_neg(input int k, input int n);
    int a;
    a = phase_idx(k, n);
    return (a > 8) && (a < 24);
  endfunction

  // Q7 magnitudes; index 0 is the DC weight 1/(2*sqrt 2)
  function automatic logic [CW-1:0] cos_q7(input int m);
    case (m)
      0:       return 8'd45;
      1:       return 8'd126;
      2:       return 8'd118;
      3:       return 8'd106;
      4:       return 8'd91;
      5:       return 8'd71;
      6:       return 8'd49;
      7:       return 8'd25;
      default: return 8'd0;
    endcase
  endfunction

  // row 0 carries no extra factor of one half
  function automatic int out_shift(input int k);
    return (k == 0) ? FRAC : FRAC + 1;
  endfunction

endpackage

// File: rtl/dct8_capture.sv
module dct8_capture
  import dct8_pkg::*;
#(
  parameter int LANES = 2,
  parameter int SW    = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            beat_en,
  input  logic [((NPT/LANES > 1) ? $clog2(NPT/LANES) : 1)-1:0] beat_idx,
  input  logic [LANES*SW-1:0]             beat_data,
  input  logic                            load_x,
  output logic [NPT-1:0][SW:0]            x_q
);

  localparam int NB   = NPT / LANES;
  localparam int BCW  = (NB > 1) ? $clog2(NB) : 1;
  // serial input buffers all eight; wider inputs take the last beat directly
  localparam int RAWN = (LANES == 1) ? NPT : NPT - LANES;
  localparam int RAWD = (RAWN > 0) ? RAWN : 1;

  logic [RAWD-1:0][SW-1:0] raw_q;
  logic [SW-1:0]           src [NPT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (beat_en) begin
      for (int n = 0; n < RAWN; n++) begin
        if (beat_idx == BCW'(n / LANES))
          raw_q[n] <= beat_data[(n % LANES)*SW +: SW];
      end
    end
  end

  for (genvar n = 0; n < NPT; n++) begin : g_src
    if (n < RAWN) begin : g_buf
      assign src[n] = raw_q[n];
    end else begin : g_live
      assign src[n] = beat_data[(n - RAWN)*SW +: SW];
    end
  end

  // register the group with one bit of sign extension
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
    end else if (load_x) begin
      for (int n = 0; n < NPT; n++)
        x_q[n] <= {src[n][SW-1], src[n]};
    end
  end

endmodule

// File: rtl/dct8_prep.sv
module dct8_prep
  import dct8_pkg::*;
#(
  parameter int XW = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_bfly,
  input  logic                   en_abs,
  input  logic [NPT-1:0][XW-1:0] x_q,
  output logic [NPT-1:0][XW-1:0] mag_q,
  output logic [NPT-1:0]         neg_q
);

  // slots 0..3 hold pair sums, slots 4..7 pair differences
  logic [NPT-1:0][XW-1:0] bf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bf_q <= '0;
    end else if (en_bfly) begin
      for (int i = 0; i < NHALF; i++) begin
        bf_q[i]         <= x_q[i] + x_q[NPT-1-i];
        bf_q[NHALF + i] <= x_q[i] - x_q[NPT-1-i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q <= '0;
      neg_q <= '0;
    end else if (en_abs) begin
      for (int n = 0; n < NPT; n++) begin
        neg_q[n] <= bf_q[n][XW-1];
        mag_q[n] <= bf_q[n][XW-1] ? (~bf_q[n] + 1'b1) : bf_q[n];
      end
    end
  end

endmodule

// File: rtl/dct8_mulacc.sv
module dct8_mulacc
  import dct8_pkg::*;
#(
  parameter int XW = 9,
  parameter int OW = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_mul,
  input  logic                   en_acc1,
  input  logic                   en_acc2,
  input  logic [NPT-1:0][XW-1:0] mag_q,
  input  logic [NPT-1:0]         neg_q,
  output logic [NPT-1:0][OW-1:0] coef_q
);

  localparam int PW = XW + CW;
  localparam int AW = PW + 3;
  localparam logic signed [AW-1:0] MAXV = AW'((1 <<< (OW-1)) - 1);
  localparam logic signed [AW-1:0] MINV = -AW'(1 <<< (OW-1));

  logic [NPT-1:0][CW-1:0]             cbank_q;
  logic [NPT-1:0][NHALF-1:0][PW-1:0]  prod_q;
  logic [NPT-1:0][NHALF-1:0]          pneg_q;
  logic [NPT-1:0][1:0][AW-1:0]        pair_q;
  logic [NPT-1:0][OW-1:0]             res;

  function automatic logic signed [AW-1:0] sterm(input logic [PW-1:0] p, input logic ng);
    logic signed [AW-1:0] e;
    e = signed'({{(AW-PW){1'b0}}, p});
    return ng ? -e : e;
  endfunction

  // eight cosine magnitudes, loaded at reset and held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      for (int m = 0; m < NPT; m++) cbank_q[m] <= cos_q7(m);
  end

  // unsigned products; even rows use sums, odd rows differences
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      pneg_q <= '0;
    end else if (en_mul) begin
      for (int k = 0; k < NPT; k++) begin
        for (int i = 0; i < NHALF; i++) begin
          prod_q[k][i] <= PW'(mag_q[(k % 2)*NHALF + i]) * PW'(cbank_q[cos_sel(k, i)]);
          pneg_q[k][i] <= neg_q[(k % 2)*NHALF + i] ^ cos_neg(k, i);
        end
      end
    end
  end

  // signs reapplied, first pairwise sum
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= '0;
    end else if (en_acc1) begin
      for (int k = 0; k < NPT; k++)
        for (int j = 0; j < 2; j++)
          pair_q[k][j] <= sterm(prod_q[k][2*j], pneg_q[k][2*j])
                        + sterm(prod_q[k][2*j+1], pneg_q[k][2*j+1]);
    end
  end

  // final sum, round half up, clamp
  always_comb begin
    for (int k = 0; k < NPT; k++) begin
      logic signed [AW-1:0] tot;
      tot = signed'(pair_q[k][0]) + signed'(pair_q[k][1])
          + AW'(1 <<< (out_shift(k) - 1));
      tot = tot >>> out_shift(k);
      if (tot > MAXV)      res[k] = MAXV[OW-1:0];
      else if (tot < MINV) res[k] = MINV[OW-1:0];
      else                 res[k] = tot[OW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       coef_q <= '0;
    else if (en_acc2) coef_q <= res;
  end

endmodule

// File: rtl/dct8_row.sv
module dct8_row
  import dct8_pkg::*;
#(
  parameter int LANES = 2,
  parameter int SW    = 8,
  parameter int OW    = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [LANES*SW-1:0]   in_data,
  output logic [NPT*OW-1:0]     coef_out,
  output logic                  done
);

  localparam int NB     = NPT / LANES;
  localparam int BCW    = (NB > 1) ? $clog2(NB) : 1;
  localparam int XW     = SW + 1;
  localparam bit DIRECT = (LANES > 1);

  dct_state_e             st_q;
  logic [BCW-1:0]         beat_q;
  logic                   done_q;
  logic                   beat_en, last_beat, load_x;
  logic [NPT-1:0][XW-1:0] x_q, mag_q;
  logic [NPT-1:0]         neg_q;
  logic [NPT-1:0][OW-1:0] coef_q;

  assign in_ready  = (st_q == ST_CAP);
  assign beat_en   = in_valid && in_ready;
  assign last_beat = (beat_q == BCW'(NB - 1));
  assign load_x    = (DIRECT && beat_en && last_beat) || (st_q == ST_REG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (st_q == ST_ACC2);
      case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_CAP;
          beat_q <= '0;
        end
        ST_CAP: if (beat_en) begin
          if (last_beat) st_q <= DIRECT ? ST_BFLY : ST_REG;
          else           beat_q <= beat_q + 1'b1;
        end
        ST_REG:  st_q <= ST_BFLY;
        ST_BFLY: st_q <= ST_ABS;
        ST_ABS:  st_q <= ST_MUL;
        ST_MUL:  st_q <= ST_ACC1;
        ST_ACC1: st_q <= ST_ACC2;
        ST_ACC2: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  dct8_capture #(.LANES(LANES), .SW(SW)) u_cap (
    .clk(clk), .rst_n(rst_n), .beat_en(beat_en), .beat_idx(beat_q),
    .beat_data(in_data), .load_x(load_x), .x_q(x_q)
  );

  dct8_prep #(.XW(XW)) u_prep (
    .clk(clk), .rst_n(rst_n), .en_bfly(st_q == ST_BFLY), .en_abs(st_q == ST_ABS),
    .x_q(x_q), .mag_q(mag_q), .neg_q(neg_q)
  );

  dct8_mulacc #(.XW(XW), .OW(OW)) u_mac (
    .clk(clk), .rst_n(rst_n), .en_mul(st_q == ST_MUL), .en_acc1(st_q == ST_ACC1),
    .en_acc2(st_q == ST_ACC2), .mag_q(mag_q), .neg_q(neg_q), .coef_q(coef_q)
  );

  assign coef_out = coef_q;
  assign done     = done_q;

endmodule

// File: rtl/dct8_row_chk.sv
module dct8_row_chk #(
  parameter int LANES = 2,
  parameter int OW    = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            in_ready,
  input logic [8*OW-1:0] coef_out,
  input logic            done
);

  localparam int TAIL = (LANES == 1) ? 6 : 5;

  logic ready_q;
  logic fell_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= in_ready;
  end
  assign fell_r = ready_q && !in_ready;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(coef_out));

  // R3
  tail_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fell_r, TAIL));

  // R3
  tail_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fell_r, TAIL) |-> done);

  // R5
  ready_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(start));

  // R4
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

endmodule

bind dct8_row dct8_row_chk #(.LANES(LANES), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready),
  .coef_out(coef_out), .done(done)
);

// File: tb/tb_dct8_row.sv
`timescale 1ns/1ps
module tb_dct8_row;

  localparam int LANES = 2;
  localparam int SW    = 8;
  localparam int OW    = 11;
  localparam int NPT   = 8;
  localparam int NB    = NPT / LANES;
  localparam int TOTAL = (LANES == 1) ? 14 : (LANES == 2) ? 9 : (LANES == 4) ? 7 : 6;
  localparam int TAIL  = TOTAL - NB + ((LANES == 1) ? 0 : 0);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [LANES*SW-1:0] in_data = '0;
  logic [NPT*OW-1:0]   coef_out;
  logic                done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int cq[8];

  always #10 clk = ~clk;

  dct8_row #(.LANES(LANES), .SW(SW), .OW(OW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .coef_out(coef_out), .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL R3 watchdog: got %0d cycles expected fewer than 100000", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int model_coef(input int k, input int xs[8]);
    int acc, a, m, sg, sh, r;
    acc = 0;
    for (int n = 0; n < NPT; n++) begin
      a  = ((2*n + 1) * k) % 32;
      m  = (a <= 8) ? a : (a <= 16) ? 16 - a : (a <= 24) ? a - 16 : 32 - a;
      sg = (a > 8 && a < 24) ? -1 : 1;
      acc += sg * cq[m] * xs[n];
    end
    sh = (k == 0) ? 7 : 8;
    r  = (acc + (1 << (sh - 1))) >>> sh;
    if (r > 1023)  r = 1023;
    if (r < -1024) r = -1024;
    return r;
  endfunction

  function automatic int coef_at(input int k);
    logic signed [OW-1:0] v;
    v = coef_out[k*OW +: OW];
    return int'(v);
  endfunction

  task automatic run_one(input int xs[8], input int stall_pct, input bit busy_start,
                         input string req);
    int  b, j, first_edge, exp_k;
    bit  v, fire, seen_first;
    int  held[8];
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = busy_start;
    check(in_ready === 1'b1, "R4", "in_ready after start", int'(in_ready), 1);
    b = 0; seen_first = 0; first_edge = 0;
    while (b < NB) begin
      v = ($urandom_range(99) >= stall_pct);
      in_valid = v;
      for (int l = 0; l < LANES; l++)
        in_data[l*SW +: SW] = v ? xs[b*LANES + l][SW-1:0] : SW'($urandom);
      fire = v && in_ready;
      if (fire && !seen_first) begin first_edge = cyc + 1; seen_first = 1; end
      @(negedge clk);
      if (fire) b++;
    end
    in_valid = 1'b0;
    in_data  = '0;
    check(in_ready === 1'b0, "R4", "in_ready after last beat", int'(in_ready), 0);
    j = 0;
    while (!done && j < 20) begin
      start = busy_start && (j < TAIL);
      @(negedge clk);
      j++;
    end
    start = 1'b0;
    // R3 tail after the final beat
    check(j == TAIL, "R3", "edges from last beat to done", j, TAIL);
    if (stall_pct == 0)
      check(cyc - first_edge + 1 == TOTAL, "R3", "edges from first beat to done",
            cyc - first_edge + 1, TOTAL);
    for (int k = 0; k < NPT; k++) begin
      exp_k   = model_coef(k, xs);
      held[k] = coef_at(k);
      check(held[k] == exp_k, req, $sformatf("coef %0d", k), held[k], exp_k);
    end
    @(negedge clk);
    // R6 single-cycle pulse and held output
    check(done === 1'b0, "R6", "done second cycle", int'(done), 0);
    if (busy_start)
      check(in_ready === 1'b0, "R5", "no capture after ignored start", int'(in_ready), 0);
    repeat (2) @(negedge clk);
    for (int k = 0; k < NPT; k++)
      check(coef_at(k) == held[k], "R6", $sformatf("coef %0d held", k), coef_at(k), held[k]);
  endtask

  initial begin
    int xs[8];
    void'($urandom(32'd7321));
    cq[0] = int'(128.0 / (2.0 * $sqrt(2.0)));
    for (int m = 1; m < 8; m++) cq[m] = int'(128.0 * $cos(m * 3.14159265358979 / 16.0));

    repeat (3) @(negedge clk);
    // R8 reset state
    check(done === 1'b0, "R8", "done in reset", int'(done), 0);
    check(in_ready === 1'b0, "R8", "in_ready in reset", int'(in_ready), 0);
    check(coef_out === '0, "R8", "coef_out in reset", int'(coef_out[31:0]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b0 && done === 1'b0, "R8", "idle after reset", int'(in_ready), 0);

    for (int n = 0; n < 8; n++) xs[n] = 0;
    run_one(xs, 0, 0, "R1");
    for (int n = 0; n < 8; n++) xs[n] = 127;
    run_one(xs, 0, 0, "R1");
    for (int n = 0; n < 8; n++) xs[n] = -128;
    run_one(xs, 0, 0, "R9");
    for (int n = 0; n < 8; n++) xs[n] = (n % 2) ? -128 : 127;
    run_one(xs, 0, 0, "R9");
    for (int n = 0; n < 8; n++) xs[n] = (n == 0) ? 100 : 0;
    run_one(xs, 0, 0, "R2");
    for (int n = 0; n < 8; n++) xs[n] = (n == 7) ? -77 : 0;
    run_one(xs, 0, 0, "R2");
    for (int n = 0; n < 8; n++) xs[n] = 16 * n - 50;
    run_one(xs, 0, 0, "R2");
    for (int n = 0; n < 8; n++) xs[n] = (n == 3) ? 1 : 0;
    run_one(xs, 0, 0, "R7");
    for (int n = 0; n < 8; n++) xs[n] = -1;
    run_one(xs, 0, 0, "R7");
    for (int n = 0; n < 8; n++) xs[n] = 3 - n;
    run_one(xs, 60, 0, "R4");
    for (int n = 0; n < 8; n++) xs[n] = 40 * ((n * 5) % 7) - 120;
    run_one(xs, 0, 1, "R5");

    for (int t = 0; t < 40; t++) begin
      for (int n = 0; n < 8; n++) xs[n] = $urandom_range(255) - 128;
      run_one(xs, (t % 2) ? 35 : 0, (t % 5) == 4, "R1");
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule